// File: doc/BRIEF.md
# Interrupt Flag and Overflow Tracker

This block keeps the interrupt state of eight channels fed by a conversion sequencer. Each channel carries a sticky flag that its end-of-conversion trigger sets. A separate overflow bit records that a trigger arrived while the flag was still pending. Software reads the flags and overflow bits through a small register bus and clears either set of bits by writing ones to a dedicated clear location.

For each trigger the block also emits a single-cycle interrupt pulse. In continuous mode every trigger produces a pulse. Otherwise a trigger that finds its flag already pending produces no pulse. The bus, triggers and mode settings are plain control pins: no data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Register map, with channel n at bit n and bits 15..8 always read as zero:

| Offset | Access | Meaning |
|---|---|---|
| 04h | read | channel flags |
| 05h | write 1 to clear, reads 0 | flag clear |
| 06h | read | overflow bits |
| 07h | write 1 to clear, reads 0 | overflow clear |

Top module: `adc_irq_tracker`

## Requirements
- R1: After reset every flag and overflow bit is zero, so reads of 04h and 06h return 0000h.
- R2: A trigger on channel n sets flag n from the next cycle. Flag n is visible at bit n of a read at offset 04h.
- R3: Writing a 1 to bit n at offset 05h clears flag n from the next cycle. A 0 in that bit leaves flag n unchanged.
- R4: If a trigger and a flag clear reach channel n in the same cycle, flag n ends up set. Overflow bit n does not change in that case, whether or not the flag was already set.
- R5: A trigger on channel n while flag n is set, with no clear of that flag in the same cycle, sets overflow bit n. This happens whatever the continuous-mode setting.
- R6: Overflow bit n reads at bit n of offset 06h. Writing a 1 to bit n at offset 07h clears it, and a 0 leaves it unchanged. Offsets 05h and 07h always read as zero.
- R7: If an overflow set from R5 and an overflow clear reach the same bit in the same cycle, the bit ends up set.
- R8: irq_pulse[n] is high in the cycle that trig_in[n] is high, when cont_mode[n] is 1 or flag n is clear. In every other cycle it is low.
- R9: Bits 15..8 of every read are zero. Writes to bits 15..8 and to offsets other than 05h and 07h change nothing. Reads of offsets other than 04h through 07h return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register offset |
| bus_wen | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| trig_in | input | 8 | Per-channel end-of-conversion trigger, one cycle per event |
| cont_mode | input | 8 | Per-channel continuous-mode setting |
| irq_pulse | output | 8 | Per-channel interrupt pulse |

## Verification
Two events can reach the same channel in one cycle. A trigger can coincide with a software flag clear, and an overflow-raising trigger can coincide with a software overflow clear. Directed steps build each collision twice, once with the flag pending and once with it clear, and then read 04h and 06h back to confirm that the set won and the overflow bit stayed as it was. Random stimulus then mixes triggers with clears on all channels. Every read and every pulse is compared with a bench model written from the requirements.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;
  localparam int unsigned CH_COUNT  = 8;
  localparam int unsigned WORD_BITS = 16;
  localparam int unsigned OFS_BITS  = 4;

  localparam int unsigned OFS_FLAG  = 4;
  localparam int unsigned OFS_FCLR  = 5;
  localparam int unsigned OFS_OVF   = 6;
  localparam int unsigned OFS_OCLR  = 7;
endpackage

// File: rtl/adc_irq_regif.sv
module adc_irq_regif
  import adc_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = CH_COUNT,
  parameter int unsigned REG_W  = WORD_BITS,
  parameter int unsigned ADDR_W = OFS_BITS
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wen,
  input  logic [REG_W-1:0]  wdata,
  input  logic [NUM_CH-1:0] flag,
  input  logic [NUM_CH-1:0] ovf,
  output logic [NUM_CH-1:0] flag_clr,
  output logic [NUM_CH-1:0] ovf_clr,
  output logic [REG_W-1:0]  rdata
);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(OFS_FLAG);
  localparam logic [ADDR_W-1:0] A_FCLR = ADDR_W'(OFS_FCLR);
  localparam logic [ADDR_W-1:0] A_OVF  = ADDR_W'(OFS_OVF);
  localparam logic [ADDR_W-1:0] A_OCLR = ADDR_W'(OFS_OCLR);

  always_comb begin
    flag_clr = '0;
    ovf_clr  = '0;
    if (wen && addr == A_FCLR) flag_clr = wdata[NUM_CH-1:0];
    if (wen && addr == A_OCLR) ovf_clr  = wdata[NUM_CH-1:0];
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_FLAG:  rdata[NUM_CH-1:0] = flag;
      A_OVF:   rdata[NUM_CH-1:0] = ovf;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/adc_irq_channel.sv
module adc_irq_channel (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic cont,
  input  logic flag_clr,
  input  logic ovf_clr,
  output logic flag,
  output logic ovf,
  output logic pulse
);
  logic ovf_hit;

  assign ovf_hit = trig && flag && !flag_clr;
  assign pulse   = trig && (cont || !flag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      if (trig)          flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      if (ovf_hit)       ovf  <= 1'b1;
      else if (ovf_clr)  ovf  <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_irq_tracker.sv
module adc_irq_tracker
  import adc_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = CH_COUNT,
  parameter int unsigned REG_W  = WORD_BITS,
  parameter int unsigned ADDR_W = OFS_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [NUM_CH-1:0] trig_in,
  input  logic [NUM_CH-1:0] cont_mode,
  output logic [NUM_CH-1:0] irq_pulse
);
  logic [NUM_CH-1:0] flag_q;
  logic [NUM_CH-1:0] ovf_q;
  logic [NUM_CH-1:0] fclr_w;
  logic [NUM_CH-1:0] oclr_w;

  adc_irq_regif #(.NUM_CH(NUM_CH), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regif (
    .addr     (bus_addr),
    .wen      (bus_wen),
    .wdata    (bus_wdata),
    .flag     (flag_q),
    .ovf      (ovf_q),
    .flag_clr (fclr_w),
    .ovf_clr  (oclr_w),
    .rdata    (bus_rdata)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    adc_irq_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig     (trig_in[g]),
      .cont     (cont_mode[g]),
      .flag_clr (fclr_w[g]),
      .ovf_clr  (oclr_w[g]),
      .flag     (flag_q[g]),
      .ovf      (ovf_q[g]),
      .pulse    (irq_pulse[g])
    );
  end
endmodule

// File: rtl/adc_irq_checker.sv
module adc_irq_checker
  import adc_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = CH_COUNT,
  parameter int unsigned REG_W  = WORD_BITS,
  parameter int unsigned ADDR_W = OFS_BITS
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wen,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic [NUM_CH-1:0] trig_in,
  input logic [NUM_CH-1:0] irq_pulse,
  input logic [NUM_CH-1:0] flag_q,
  input logic [NUM_CH-1:0] ovf_q
);
  logic [NUM_CH-1:0] fclr_m;
  logic [NUM_CH-1:0] oclr_m;

  assign fclr_m = (bus_wen && bus_addr == ADDR_W'(OFS_FCLR)) ? bus_wdata[NUM_CH-1:0] : '0;
  assign oclr_m = (bus_wen && bus_addr == ADDR_W'(OFS_OCLR)) ? bus_wdata[NUM_CH-1:0] : '0;

  assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & $past(trig_in)) == $past(trig_in));

  assert_flag_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & $past(fclr_m & ~trig_in)) == '0);

  assert_collide_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_q ^ $past(ovf_q)) & $past(trig_in & fclr_m & ~oclr_m)) == '0);

  assert_ovf_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q & ~$past(ovf_q) & ~$past(trig_in & flag_q & ~fclr_m)) == '0);

  assert_ovf_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q & $past(trig_in & flag_q & ~fclr_m)) == $past(trig_in & flag_q & ~fclr_m));

  assert_pulse_needs_trig_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse & ~trig_in) == '0);

  assert_first_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_in & ~flag_q & ~irq_pulse) == '0);

  assert_rsv_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[REG_W-1:NUM_CH] == '0);
endmodule

bind adc_irq_tracker adc_irq_checker #(.NUM_CH(NUM_CH), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wen   (bus_wen),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .trig_in   (trig_in),
  .irq_pulse (irq_pulse),
  .flag_q    (flag_q),
  .ovf_q     (ovf_q)
);

// File: tb/test_adc_irq_tracker.sv
module test_adc_irq_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  trig_in = '0;
  logic [7:0]  cont_mode = '0;
  logic [7:0]  irq_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] m_flag = '0;
  logic [7:0] m_ovf = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_irq_tracker i_adc_irq_tracker (
    .clk, .rst_n, .bus_addr, .bus_wen, .bus_wdata, .bus_rdata,
    .trig_in, .cont_mode, .irq_pulse
  );

  function automatic logic [15:0] exp_read(input logic [3:0] a);
    if (a == 4'h4) return {8'h00, m_flag};
    if (a == 4'h6) return {8'h00, m_ovf};
    return 16'h0000;
  endfunction

  function automatic logic [7:0] exp_pulse(input logic [7:0] t, input logic [7:0] c);
    return t & (c | ~m_flag);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, check combinational outputs, then update the model at the rising edge.
  task automatic step(input string req, input logic [3:0] a, input logic w,
                      input logic [15:0] d, input logic [7:0] t, input logic [7:0] c);
    logic [7:0] fclr, oclr, oset;
    @(negedge clk);
    bus_addr = a; bus_wen = w; bus_wdata = d; trig_in = t; cont_mode = c;
    #1;
    check(req, bus_rdata, exp_read(a));
    check("R8", {8'h00, irq_pulse}, {8'h00, exp_pulse(t, c)});
    fclr = (w && a == 4'h5) ? d[7:0] : 8'h00;
    oclr = (w && a == 4'h7) ? d[7:0] : 8'h00;
    oset = t & m_flag & ~fclr;
    @(posedge clk);
    m_ovf  = oset | (m_ovf & ~oclr);
    m_flag = t | (m_flag & ~fclr);
  endtask

  task automatic idle(input string req, input logic [3:0] a);
    step(req, a, 1'b0, 16'h0000, 8'h00, 8'h00);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [3:0] a;
    logic [15:0] d;
    logic [7:0] t, c;
    logic w;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    idle("R1", 4'h4);
    idle("R1", 4'h6);
    // R2 trigger sets flag
    step("R2", 4'h4, 1'b0, 16'h0, 8'h01, 8'h00);
    idle("R2", 4'h4);
    // R5 trigger on pending flag, non-continuous (pulse suppressed, R8)
    step("R5", 4'h6, 1'b0, 16'h0, 8'h01, 8'h00);
    idle("R5", 4'h6);
    // R5 in continuous mode on channel 1
    step("R5", 4'h6, 1'b0, 16'h0, 8'h02, 8'h02);
    step("R5", 4'h6, 1'b0, 16'h0, 8'h02, 8'h02);
    idle("R5", 4'h6);
    // R3 zero write leaves flags, one clears
    step("R3", 4'h5, 1'b1, 16'h0000, 8'h00, 8'h00);
    idle("R3", 4'h4);
    step("R3", 4'h5, 1'b1, 16'h0001, 8'h00, 8'h00);
    idle("R3", 4'h4);
    // R4 collision with flag pending and with flag clear
    step("R4", 4'h4, 1'b0, 16'h0, 8'h04, 8'h00);
    step("R4", 4'h5, 1'b1, 16'h000C, 8'h0C, 8'h00);
    idle("R4", 4'h4);
    idle("R4", 4'h6);
    // R7 overflow set vs overflow clear on channel 0 (flag 0 cleared above)
    step("R7", 4'h4, 1'b0, 16'h0, 8'h01, 8'h00);
    step("R7", 4'h7, 1'b1, 16'h0001, 8'h01, 8'h00);
    idle("R7", 4'h6);
    // R6 clear overflow, clear registers read zero
    step("R6", 4'h7, 1'b1, 16'h0000, 8'h00, 8'h00);
    idle("R6", 4'h6);
    step("R6", 4'h7, 1'b1, 16'h00FF, 8'h00, 8'h00);
    idle("R6", 4'h6);
    idle("R6", 4'h5);
    idle("R6", 4'h7);
    // R9 reserved bits and unmapped offsets
    step("R9", 4'h5, 1'b1, 16'hFF00, 8'h00, 8'h00);
    idle("R9", 4'h4);
    step("R9", 4'hC, 1'b1, 16'hFFFF, 8'h00, 8'h00);
    step("R9", 4'h3, 1'b1, 16'hFFFF, 8'h00, 8'h00);
    idle("R9", 4'h4);
    step("R9", 4'h4, 1'b1, 16'hFFFF, 8'hF0, 8'h00);
    step("R9", 4'h6, 1'b1, 16'hFFFF, 8'hF0, 8'h00);
    idle("R9", 4'h6);
    idle("R9", 4'hC);

    // Random mix of triggers and clears
    for (int i = 0; i < 3000; i++) begin
      a = ($urandom % 4 == 0) ? 4'($urandom) : 4'(4 + $urandom % 4);
      w = ($urandom % 3 == 0);
      d = 16'($urandom);
      t = 8'($urandom) & 8'($urandom);
      c = 8'($urandom);
      if (a == 4'h4 || a == 4'h5) step("R3", a, w, d, t, c);
      else if (a == 4'h6 || a == 4'h7) step("R6", a, w, d, t, c);
      else step("R9", a, w, d, t, c);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule